// File: doc/BRIEF.md
# Read-Protected Configuration Store

This block keeps the configuration words of a small programmable logic array together with a separate 64-bit user signature. It also decides what a host may read back. A register array stands in for the non-volatile cells. The host drives one command per cycle on a valid/opcode/address/data port, and the command is taken only while `busy` is low.

A program session always begins with an automatic erase sweep. The sweep sets every configuration word and the signature to all ones and releases the read lock. After the sweep the host writes words and signature halves one at a time. Setting the lock makes every later configuration read return zero, with a one-cycle denial flag. The lock is sticky: only the next program session clears it. The signature stays readable, and a checksum sweep folds both the words and the signature into one modular sum.

Command encoding on `cmd_op`:

| Code | Command |
|------|---------|
| 0 | no operation |
| 1 | start a program session (erase sweep) |
| 2 | write one configuration word |
| 3 | write one signature half |
| 4 | read one configuration word |
| 5 | read one signature half |
| 6 | set the lock |
| 7 | start a checksum sweep |

Top module: `cfg_store`

## Requirements
- R1: After reset, `busy`, `rd_valid`, `access_denied` and `sum_done` are 0, every configuration word and every signature half reads all ones, and the lock is clear.
- R2: Op 2 writes `cmd_wdata` to the word at `cmd_addr`. Op 4 reads that word back: `rd_valid` is high for exactly the one cycle after the accepting edge, with the data on `rd_data`.
- R3: The 64-bit signature is split into W-bit halves. Half k holds bits [W*k+W-1:W*k], and k is taken from the low bits of `cmd_addr`. Op 3 writes half k and op 5 reads it.
- R4: While the lock is set, op 4 returns `rd_data` = 0 with `rd_valid` = 1, and `access_denied` is high for that one cycle only.
- R5: Op 5 returns the signature half whether or not the lock is set, and it never raises `access_denied`.
- R6: While the lock is set, ops 2 and 3 change no stored value.
- R7: Op 6 sets the lock. Only op 1 clears it, and no other command does. Op 1 sets every word and the signature to all ones.
- R8: After op 1, `busy` is high for exactly DEPTH cycles. After op 7, it is high for exactly DEPTH + SIG_W/W cycles.
- R9: After a checksum sweep, `sum_done` pulses for one cycle as `busy` falls. `sum_value` then holds the sum, modulo 2^W, of all configuration words and all signature halves, and keeps it until the next sweep ends. The sweep also runs while the lock is set.
- R10: Any command presented while `busy` is high is ignored: no read response, no write, no lock change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (table above) |
| cmd_addr | input | AW | Word index, or signature half index in the low bits |
| cmd_wdata | input | W | Data for write commands |
| busy | output | 1 | An erase or checksum sweep is running |
| rd_valid | output | 1 | Read response valid (one cycle) |
| rd_data | output | W | Read response data |
| access_denied | output | 1 | Configuration read refused (one cycle) |
| sum_done | output | 1 | Checksum sweep finished (one cycle) |
| sum_value | output | W | Last computed checksum |

## Verification
The bench builds the block with W = 16, DEPTH = 8 and SIG_W = 64, which gives four signature halves and a 12-step checksum sweep. These small sizes let a reference model mirror every stored word and count each sweep's busy cycles against its exact length. With 16-bit random data, the modular sum wraps past 2^16 on most sweeps. The short sweep also leaves room to inject commands while `busy` is high and to step through the whole lock, refuse and reprogram cycle several times.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_PROGRAM = 3'd1,
      OP_WR_WORD = 3'd2,
      OP_WR_SIG  = 3'd3,
      OP_RD_WORD = 3'd4,
      OP_RD_SIG  = 3'd5,
      OP_LOCK    = 3'd6,
      OP_SUM     = 3'd7
   } op_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ERASE = 2'd1,
      SQ_SUM   = 2'd2
   } seq_e;
endpackage

// File: rtl/cfg_store_mem.sv
module cfg_store_mem #(
   parameter int W     = 16,
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [W-1:0]  rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [W-1:0]  rdata_b
);
   logic [W-1:0] cells [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cells[i] <= '1;
         else if (we && waddr == AW'(i))
            cells[i] <= wdata;
      end
   end

   assign rdata_a = cells[raddr_a];
   assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/cfg_store_sig.sv
module cfg_store_sig #(
   parameter int W      = 16,
   parameter int HALVES = 4,
   parameter int HW     = (HALVES > 1) ? $clog2(HALVES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fill,
   input  logic          we,
   input  logic [HW-1:0] widx,
   input  logic [W-1:0]  wdata,
   input  logic [HW-1:0] ridx_a,
   output logic [W-1:0]  rdata_a,
   input  logic [HW-1:0] ridx_b,
   output logic [W-1:0]  rdata_b
);
   logic [W-1:0] part [HALVES];

   for (genvar k = 0; k < HALVES; k++) begin : g_part
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            part[k] <= '1;
         else if (fill)
            part[k] <= '1;
         else if (we && widx == HW'(k))
            part[k] <= wdata;
      end
   end

   assign rdata_a = part[ridx_a];
   assign rdata_b = part[ridx_b];
endmodule

// File: rtl/cfg_store_seq.sv
module cfg_store_seq
   import cfg_store_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int HALVES = 4,
   parameter int TOTAL  = DEPTH + HALVES,
   parameter int IW     = $clog2(TOTAL + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_erase,
   input  logic          start_sum,
   output logic          busy,
   output logic          erasing,
   output logic          summing,
   output logic          last,
   output logic [IW-1:0] idx
);
   seq_e state;

   assign erasing = (state == SQ_ERASE);
   assign summing = (state == SQ_SUM);
   assign busy    = erasing || summing;
   assign last    = (erasing && idx == IW'(DEPTH - 1)) ||
                    (summing && idx == IW'(TOTAL - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         idx   <= '0;
      end else if (!busy) begin
         idx <= '0;
         if (start_erase)
            state <= SQ_ERASE;
         else if (start_sum)
            state <= SQ_SUM;
      end else if (last) begin
         state <= SQ_IDLE;
         idx   <= '0;
      end else begin
         idx <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
   import cfg_store_pkg::*;
#(
   parameter int W     = 16,
   parameter int DEPTH = 16,
   parameter int SIG_W = 64,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [2:0]    cmd_op,
   input  logic [AW-1:0] cmd_addr,
   input  logic [W-1:0]  cmd_wdata,
   output logic          busy,
   output logic          rd_valid,
   output logic [W-1:0]  rd_data,
   output logic          access_denied,
   output logic          sum_done,
   output logic [W-1:0]  sum_value
);
   localparam int HALVES = SIG_W / W;
   localparam int HW     = (HALVES > 1) ? $clog2(HALVES) : 1;
   localparam int TOTAL  = DEPTH + HALVES;
   localparam int IW     = $clog2(TOTAL + 1);

   if (SIG_W % W != 0) begin : g_bad_split
      $error("SIG_W must be a whole multiple of W");
   end
   if (HALVES > DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2 and cover the signature half index");
   end

   op_e           op;
   logic          accept, lock_q;
   logic          seq_erasing, seq_summing, seq_last;
   logic [IW-1:0] seq_idx;
   logic          mem_we;
   logic [AW-1:0] mem_waddr;
   logic [W-1:0]  mem_wdata, mem_rd_cmd, mem_rd_seq;
   logic [W-1:0]  sig_rd_cmd, sig_rd_seq, elem, acc;

   assign op     = op_e'(cmd_op);
   assign accept = cmd_valid && !busy;

   cfg_store_seq #(.DEPTH(DEPTH), .HALVES(HALVES), .TOTAL(TOTAL), .IW(IW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_erase (accept && op == OP_PROGRAM),
      .start_sum   (accept && op == OP_SUM),
      .busy        (busy),
      .erasing     (seq_erasing),
      .summing     (seq_summing),
      .last        (seq_last),
      .idx         (seq_idx)
   );

   // The sweep owns the write port while busy; host writes need !busy.
   assign mem_we    = seq_erasing || (accept && op == OP_WR_WORD && !lock_q);
   assign mem_waddr = seq_erasing ? AW'(seq_idx) : cmd_addr;
   assign mem_wdata = seq_erasing ? '1 : cmd_wdata;

   cfg_store_mem #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (mem_we),
      .waddr   (mem_waddr),
      .wdata   (mem_wdata),
      .raddr_a (cmd_addr),
      .rdata_a (mem_rd_cmd),
      .raddr_b (AW'(seq_idx)),
      .rdata_b (mem_rd_seq)
   );

   cfg_store_sig #(.W(W), .HALVES(HALVES), .HW(HW)) u_sig (
      .clk     (clk),
      .rst_n   (rst_n),
      .fill    (accept && op == OP_PROGRAM),
      .we      (accept && op == OP_WR_SIG && !lock_q),
      .widx    (HW'(cmd_addr)),
      .wdata   (cmd_wdata),
      .ridx_a  (HW'(cmd_addr)),
      .rdata_a (sig_rd_cmd),
      .ridx_b  (HW'(seq_idx - IW'(DEPTH))),
      .rdata_b (sig_rd_seq)
   );

   assign elem = (seq_idx < IW'(DEPTH)) ? mem_rd_seq : sig_rd_seq;

   // Sticky lock: only a program session releases it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lock_q <= 1'b0;
      else if (accept && op == OP_PROGRAM)
         lock_q <= 1'b0;
      else if (accept && op == OP_LOCK)
         lock_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid      <= 1'b0;
         rd_data       <= '0;
         access_denied <= 1'b0;
      end else begin
         rd_valid      <= accept && (op == OP_RD_WORD || op == OP_RD_SIG);
         access_denied <= accept && op == OP_RD_WORD && lock_q;
         if (accept && op == OP_RD_WORD)
            rd_data <= lock_q ? '0 : mem_rd_cmd;
         else if (accept && op == OP_RD_SIG)
            rd_data <= sig_rd_cmd;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc       <= '0;
         sum_value <= '0;
         sum_done  <= 1'b0;
      end else begin
         sum_done <= seq_summing && seq_last;
         if (accept && op == OP_SUM)
            acc <= '0;
         else if (seq_summing && seq_last)
            sum_value <= acc + elem;
         else if (seq_summing)
            acc <= acc + elem;
      end
   end
endmodule

// File: rtl/cfg_store_chk.sv
module cfg_store_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cmd_valid,
   input logic [2:0]   cmd_op,
   input logic         busy,
   input logic         rd_valid,
   input logic [W-1:0] rd_data,
   input logic         access_denied,
   input logic         sum_done,
   input logic         lock_q
);
   // R4
   denied_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      access_denied |-> (rd_valid && rd_data == '0));

   // R4
   denied_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      access_denied |-> $past(lock_q));

   // R7
   lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_q) |-> $past(cmd_valid && !busy && cmd_op == 3'd1));

   // R10
   rd_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(cmd_valid && !busy));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sum_done |=> !sum_done);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sum_done |-> (!busy && $past(busy)));
endmodule

bind cfg_store cfg_store_chk #(.W(W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_valid     (cmd_valid),
   .cmd_op        (cmd_op),
   .busy          (busy),
   .rd_valid      (rd_valid),
   .rd_data       (rd_data),
   .access_denied (access_denied),
   .sum_done      (sum_done),
   .lock_q        (lock_q)
);

// File: tb/cfg_store_test.sv
module cfg_store_test;
   localparam int W      = 16;
   localparam int DEPTH  = 8;
   localparam int SIG_W  = 64;
   localparam int HALVES = SIG_W / W;
   localparam int AW     = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = '0;
   logic [AW-1:0] cmd_addr = '0;
   logic [W-1:0]  cmd_wdata = '0;
   logic          busy, rd_valid, access_denied, sum_done;
   logic [W-1:0]  rd_data, sum_value;

   int checks = 0;
   int errors = 0;

   logic [W-1:0] m_mem [DEPTH];
   logic [W-1:0] m_sig [HALVES];

   always #5 clk = ~clk;

   cfg_store #(.W(W), .DEPTH(DEPTH), .SIG_W(SIG_W)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
      .rd_valid(rd_valid), .rd_data(rd_data), .access_denied(access_denied),
      .sum_done(sum_done), .sum_value(sum_value)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] model_sum();
      logic [W-1:0] s = '0;
      for (int i = 0; i < DEPTH; i++) s += m_mem[i];
      for (int k = 0; k < HALVES; k++) s += m_sig[k];
      return s;
   endfunction

   function automatic void model_erase();
      for (int i = 0; i < DEPTH; i++) m_mem[i] = '1;
      for (int k = 0; k < HALVES; k++) m_sig[k] = '1;
   endfunction

   // Drive one command for one cycle; returns at the negedge after the edge.
   task automatic issue(input logic [2:0] op, input int addr, input logic [W-1:0] data);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_addr  = AW'(addr);
      cmd_wdata = data;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_op    = 3'd0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic rd_word(input string req, input int addr, input bit locked);
      issue(3'd4, addr, '0);
      check(req, {31'd0, rd_valid}, 32'd1);
      check(req, 32'(rd_data), locked ? 32'd0 : 32'(m_mem[addr]));
      check(req, {31'd0, access_denied}, {31'd0, locked});
   endtask

   task automatic rd_sig(input string req, input int k);
      issue(3'd5, k, '0);
      check(req, {31'd0, rd_valid}, 32'd1);
      check(req, 32'(rd_data), 32'(m_sig[k]));
      check(req, {31'd0, access_denied}, 32'd0);
   endtask

   task automatic program_start(input string req);
      int n;
      issue(3'd1, 0, '0);
      model_erase();
      wait_idle(n);
      check(req, 32'(n), 32'(DEPTH));
   endtask

   task automatic run_sum(input string req);
      int n;
      issue(3'd7, 0, '0);
      wait_idle(n);
      check({req, " busy length"}, 32'(n), 32'(DEPTH + HALVES));
      check({req, " done"}, {31'd0, sum_done}, 32'd1);
      check({req, " value"}, 32'(sum_value), 32'(model_sum()));
      @(negedge clk);
      check({req, " done pulse"}, {31'd0, sum_done}, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] v, prev_sum;
      int a, n;
      void'($urandom(32'd4711));
      model_erase();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 busy", {31'd0, busy}, 32'd0);
      check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
      check("R1 denied", {31'd0, access_denied}, 32'd0);
      check("R1 done", {31'd0, sum_done}, 32'd0);
      for (int i = 0; i < DEPTH; i++) rd_word("R1 word erased", i, 1'b0);
      for (int k = 0; k < HALVES; k++) rd_sig("R1 sig erased", k);
      @(negedge clk);
      check("R2 rd_valid one cycle", {31'd0, rd_valid}, 32'd0);

      // R8 program session erase length
      program_start("R8 erase length");

      // R2 R3 directed fill then random mix
      for (int i = 0; i < DEPTH; i++) begin
         v = W'($urandom);
         issue(3'd2, i, v);
         m_mem[i] = v;
      end
      for (int k = 0; k < HALVES; k++) begin
         v = W'($urandom);
         issue(3'd3, k, v);
         m_sig[k] = v;
      end
      for (int it = 0; it < 80; it++) begin
         a = $urandom_range(0, 3);
         v = W'($urandom);
         case (a)
            0: begin n = $urandom_range(0, DEPTH - 1); issue(3'd2, n, v); m_mem[n] = v; end
            1: begin n = $urandom_range(0, HALVES - 1); issue(3'd3, n, v); m_sig[n] = v; end
            2: rd_word("R2 word readback", $urandom_range(0, DEPTH - 1), 1'b0);
            default: rd_sig("R3 sig half readback", $urandom_range(0, HALVES - 1));
         endcase
      end

      // R9 checksum
      run_sum("R9 checksum");
      prev_sum = sum_value;

      // R9 signature change moves checksum
      issue(3'd3, 2, m_sig[2] ^ 16'h0100);
      m_sig[2] ^= 16'h0100;
      run_sum("R9 sig in checksum");
      check("R9 sig changes sum", {31'd0, sum_value != prev_sum}, 32'd1);

      // R10 commands during a sweep are ignored
      issue(3'd7, 0, '0);
      issue(3'd2, 0, ~m_mem[0]);
      issue(3'd4, 1, '0);
      check("R10 no read while busy", {31'd0, rd_valid}, 32'd0);
      issue(3'd6, 0, '0);
      wait_idle(n);
      @(negedge clk);
      check("R9 sum held", 32'(sum_value), 32'(model_sum()));
      rd_word("R10 word unchanged, lock unchanged", 0, 1'b0);

      // R4 R5 R6 R7 lock behaviour
      issue(3'd6, 0, '0);
      for (int i = 0; i < DEPTH; i++) rd_word("R4 locked word read", i, 1'b1);
      @(negedge clk);
      check("R4 denied one cycle", {31'd0, access_denied}, 32'd0);
      for (int k = 0; k < HALVES; k++) rd_sig("R5 sig readable locked", k);
      issue(3'd3, 1, ~m_sig[1]);
      rd_sig("R6 sig write ignored", 1);
      issue(3'd2, 3, ~m_mem[3]);
      issue(3'd2, 5, m_mem[5] + 16'd7);
      run_sum("R6 word write ignored (sum) R9 locked");
      issue(3'd6, 0, '0);
      issue(3'd0, 0, '0);
      issue(3'd5, 0, '0);
      rd_word("R7 lock persists", 4, 1'b1);

      // R7 program session clears lock and erases
      program_start("R7 R8 erase length");
      for (int i = 0; i < DEPTH; i++) rd_word("R7 unlocked erased word", i, 1'b0);
      for (int k = 0; k < HALVES; k++) rd_sig("R7 erased sig", k);
      run_sum("R9 erased sum");
      check("R9 erased sum value", 32'(sum_value), 32'(16'hFFF4));

      // R9 wraparound with all zeros words and signature ones
      for (int i = 0; i < DEPTH; i++) begin issue(3'd2, i, '0); m_mem[i] = '0; end
      run_sum("R9 partial sum");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule